// File: doc/BRIEF.md
# Low-Power Watch Mode Controller

This block sequences the operating mode of a small microcontroller core. It reports one of four modes: full-speed active, medium-speed active, subactive, or watch. It drives a clock enable for each peripheral, a gate for the CPU clock, and a one-cycle pulse that starts interrupt exception handling after a wake-up. Software controls it through a sleep strobe and a few control bits. The bits select standby, low speed, medium speed and the timer clock. A 3-bit field picks the oscillator settling delay.

When software issues a sleep with standby and timer clock selected, the core enters watch mode. Only the timers and the paging decoder keep their clocks. A qualified interrupt ends watch mode. The speed bits then choose the mode the core returns to. A return to an active mode first waits out the selected settling interval. A return to subactive mode follows at once. When standby is not selected, a sleep only stops the CPU clock until an interrupt arrives.

Top module: `wmode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: mode 0 (full-speed active), every `periph_ce` bit 1, `cpu_ce` 1, `exc_start` 0. The settling counter is cleared.
- R2: In a running mode (0, 1 or 2, with `cpu_ce` high), a sleep strobe with `stby_sel`=1 and `tclk_sel`=1 puts the block in mode 3 (watch) at the next edge.
- R3: While the mode is 3, `periph_ce` equals `WATCH_KEEP` and `cpu_ce` is 0. `WATCH_KEEP` keeps bits 0..3 on: timer A, timer F, timer G and the paging decoder.
- R4: A source counts as a wake request only if its `src_pend` bit is 1, its `src_en` bit is 1 and `irq_mask` is 0. Source bits are: 0 timer A, 1 timer F, 2 timer G, 3 IRQ0, 4..11 wake pins 0..7. Any other pending source leaves the block in watch or doze.
- R5: A wake request in watch with `lspd_sel`=1 gives mode 2 (subactive), with `exc_start` high, at the next edge. No settling wait is made.
- R6: A wake request in watch with `lspd_sel`=0 returns to mode 1 when `mspd_sel`=1, and to mode 0 when `mspd_sel`=0. All clock enables come back on, together with an `exc_start` pulse.
- R7: For an active target, the mode stays 3 for 2^(4+7-`settle_sel`) edges, counting the wake edge. The mode changes on the edge after those. `settle_sel`=7 gives 16 edges and `settle_sel`=0 gives 2048 edges.
- R8: `exc_start` is high for exactly one cycle per wake-up. Several sources pending at once, or left pending afterwards, give a single pulse.
- R9: A sleep strobe during the settling count has no effect.
- R10: A sleep strobe with `stby_sel`=0 keeps the mode and the peripheral enables and drops `cpu_ce`. A later wake request restores `cpu_ce` and pulses `exc_start`.
- R11: A sleep strobe with `stby_sel`=1 and `tclk_sel`=0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| sleep_i | input | 1 | Sleep instruction strobe |
| stby_sel | input | 1 | Standby select |
| lspd_sel | input | 1 | Low-speed (subactive) wake target select |
| mspd_sel | input | 1 | Medium-speed active wake target select |
| tclk_sel | input | 1 | Timer clock select, needed for watch entry |
| settle_sel | input | 3 | Oscillator settling interval select |
| irq_mask | input | 1 | Global interrupt mask |
| src_en | input | N_SRC | Per-source interrupt enables |
| src_pend | input | N_SRC | Pending interrupt flags |
| mode_o | output | 2 | Current mode: 0 full-speed, 1 medium-speed, 2 subactive, 3 watch |
| periph_ce | output | N_PERIPH | Per-peripheral clock enables |
| cpu_ce | output | 1 | CPU clock gate |
| exc_start | output | 1 | Exception-handling start pulse |

## Verification
The assertions assume that reset is applied before the first interesting edge. They also assume that the speed-select bits do not change in the cycle in which a wake request is taken. Pending flags stay up until the stimulus clears them, as software would. The bench changes every input on the falling edge, so inputs are stable at each rising edge. It sets the speed bits before it raises any pending flag, and it drops the sleep strobe before the settling count ends. This way a new watch entry is never made in the same stretch as the exit being checked.

// File: rtl/wmode_pkg.sv
package wmode_pkg;
  typedef enum logic [1:0] {
    MODE_ACT_HI  = 2'd0,
    MODE_ACT_MED = 2'd1,
    MODE_SUBACT  = 2'd2,
    MODE_WATCH   = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOZE   = 2'd1,
    ST_WATCH  = 2'd2,
    ST_SETTLE = 2'd3
  } wseq_e;
endpackage

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int N_SRC = 12
) (
  input  logic             irq_mask,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_pend,
  output logic             wake_req
);
  logic [N_SRC-1:0] live;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign live[s] = src_pend[s] & src_en[s];
  end

  assign wake_req = !irq_mask && (|live);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SEL_W           = 3,
  parameter int SETTLE_MIN_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             busy,
  output logic             done
);
  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int CNT_W   = SETTLE_MIN_LOG2 + MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  function automatic logic [CNT_W-1:0] start_val(input logic [SEL_W-1:0] s);
    int sh;
    longint full;
    sh   = SETTLE_MIN_LOG2 + MAX_SEL - int'(s);
    full = (64'd1 << sh) - 64'd1;
    return CNT_W'(full);
  endfunction

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= start_val(sel);
      busy_q <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wmode_fsm.sv
module wmode_fsm
  import wmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_i,
  input  logic       stby_sel,
  input  logic       lspd_sel,
  input  logic       mspd_sel,
  input  logic       tclk_sel,
  input  logic       wake_req,
  input  logic       settle_done,
  output logic       settle_load,
  output wmode_e     mode_q,
  output wmode_e     mode_d,
  output logic       cpu_ce_q,
  output logic       exc_q
);
  wseq_e  st_q, st_d;
  wmode_e tgt_q, tgt_d;
  logic   cpu_d, exc_d;

  always_comb begin
    st_d        = st_q;
    mode_d      = mode_q;
    tgt_d       = tgt_q;
    cpu_d       = cpu_ce_q;
    exc_d       = 1'b0;
    settle_load = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (sleep_i && stby_sel && tclk_sel) begin
          st_d   = ST_WATCH;
          mode_d = MODE_WATCH;
          cpu_d  = 1'b0;
        end else if (sleep_i && !stby_sel) begin
          st_d  = ST_DOZE;
          cpu_d = 1'b0;
        end
      end
      ST_DOZE: begin
        if (wake_req) begin
          st_d  = ST_RUN;
          cpu_d = 1'b1;
          exc_d = 1'b1;
        end
      end
      ST_WATCH: begin
        if (wake_req) begin
          if (lspd_sel) begin
            st_d   = ST_RUN;
            mode_d = MODE_SUBACT;
            cpu_d  = 1'b1;
            exc_d  = 1'b1;
          end else begin
            st_d        = ST_SETTLE;
            tgt_d       = mspd_sel ? MODE_ACT_MED : MODE_ACT_HI;
            settle_load = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_done) begin
          st_d   = ST_RUN;
          mode_d = tgt_q;
          cpu_d  = 1'b1;
          exc_d  = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      mode_q   <= MODE_ACT_HI;
      tgt_q    <= MODE_ACT_HI;
      cpu_ce_q <= 1'b1;
      exc_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      tgt_q    <= tgt_d;
      cpu_ce_q <= cpu_d;
      exc_q    <= exc_d;
    end
  end
endmodule

// File: rtl/clk_en_dec.sv
module clk_en_dec
  import wmode_pkg::*;
#(
  parameter int                N_PERIPH   = 8,
  parameter logic [N_PERIPH-1:0] WATCH_KEEP = 'hF
) (
  input  logic                clk,
  input  logic                rst,
  input  wmode_e              mode_d,
  output logic [N_PERIPH-1:0] ce_q
);
  logic in_watch;
  assign in_watch = (mode_d == MODE_WATCH);

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_q[p] <= 1'b1;
      else     ce_q[p] <= !in_watch || WATCH_KEEP[p];
    end
  end
endmodule

// File: rtl/wmode_ctrl.sv
module wmode_ctrl
  import wmode_pkg::*;
#(
  parameter int                  N_SRC           = 12,
  parameter int                  N_PERIPH        = 8,
  parameter logic [N_PERIPH-1:0] WATCH_KEEP      = 'hF,
  parameter int                  SEL_W           = 3,
  parameter int                  SETTLE_MIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_i,
  input  logic                stby_sel,
  input  logic                lspd_sel,
  input  logic                mspd_sel,
  input  logic                tclk_sel,
  input  logic [SEL_W-1:0]    settle_sel,
  input  logic                irq_mask,
  input  logic [N_SRC-1:0]    src_en,
  input  logic [N_SRC-1:0]    src_pend,
  output logic [1:0]          mode_o,
  output logic [N_PERIPH-1:0] periph_ce,
  output logic                cpu_ce,
  output logic                exc_start
);
  logic   wake_req, settle_load, settle_done, settle_busy;
  wmode_e mode_q, mode_d;

  wake_qual #(.N_SRC(N_SRC)) u_wake (
    .irq_mask (irq_mask),
    .src_en   (src_en),
    .src_pend (src_pend),
    .wake_req (wake_req)
  );

  settle_timer #(.SEL_W(SEL_W), .SETTLE_MIN_LOG2(SETTLE_MIN_LOG2)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .load (settle_load),
    .sel  (settle_sel),
    .busy (settle_busy),
    .done (settle_done)
  );

  wmode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sleep_i     (sleep_i),
    .stby_sel    (stby_sel),
    .lspd_sel    (lspd_sel),
    .mspd_sel    (mspd_sel),
    .tclk_sel    (tclk_sel),
    .wake_req    (wake_req),
    .settle_done (settle_done),
    .settle_load (settle_load),
    .mode_q      (mode_q),
    .mode_d      (mode_d),
    .cpu_ce_q    (cpu_ce),
    .exc_q       (exc_start)
  );

  clk_en_dec #(.N_PERIPH(N_PERIPH), .WATCH_KEEP(WATCH_KEEP)) u_ce (
    .clk    (clk),
    .rst    (rst),
    .mode_d (mode_d),
    .ce_q   (periph_ce)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/wmode_ctrl_chk.sv
module wmode_ctrl_chk #(
  parameter int                  N_SRC      = 12,
  parameter int                  N_PERIPH   = 8,
  parameter logic [N_PERIPH-1:0] WATCH_KEEP = 'hF
) (
  input logic                clk,
  input logic                rst,
  input logic                sleep_i,
  input logic                stby_sel,
  input logic                lspd_sel,
  input logic                tclk_sel,
  input logic                irq_mask,
  input logic [N_SRC-1:0]    src_en,
  input logic [N_SRC-1:0]    src_pend,
  input logic [1:0]          mode_o,
  input logic [N_PERIPH-1:0] periph_ce,
  input logic                cpu_ce,
  input logic                exc_start,
  input logic                settle_busy
);
  logic any_wake;
  assign any_wake = !irq_mask && ((src_pend & src_en) != '0);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode_o == 2'd0 && (&periph_ce) && cpu_ce && !exc_start));

  // R2
  watch_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd3 && cpu_ce && sleep_i && stby_sel && tclk_sel) |=> mode_o == 2'd3);

  // R3
  watch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd3 |-> (periph_ce == WATCH_KEEP && !cpu_ce));

  // R4
  no_masked_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3 && !settle_busy && !any_wake) |=> (mode_o == 2'd3 && !settle_busy));

  // R5
  sub_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3 && !settle_busy && any_wake && lspd_sel) |=> (mode_o == 2'd2 && exc_start));

  // R6
  settle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(settle_busy) |-> (mode_o != 2'd2 && mode_o != 2'd3 && exc_start && cpu_ce));

  // R8
  exc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exc_start |=> !exc_start);

  // R9
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    settle_busy |-> mode_o == 2'd3);
endmodule

bind wmode_ctrl wmode_ctrl_chk #(
  .N_SRC(N_SRC), .N_PERIPH(N_PERIPH), .WATCH_KEEP(WATCH_KEEP)
) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .stby_sel(stby_sel),
  .lspd_sel(lspd_sel), .tclk_sel(tclk_sel), .irq_mask(irq_mask),
  .src_en(src_en), .src_pend(src_pend), .mode_o(mode_o),
  .periph_ce(periph_ce), .cpu_ce(cpu_ce), .exc_start(exc_start),
  .settle_busy(settle_busy)
);

// File: tb/wmode_ctrl_test.sv
module wmode_ctrl_test;
  localparam int N_SRC = 12;
  localparam int N_PERIPH = 8;
  localparam logic [N_PERIPH-1:0] KEEP = 8'h0F;
  localparam logic [N_PERIPH-1:0] ALL  = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 0, stby_sel = 0, lspd_sel = 0, mspd_sel = 0, tclk_sel = 0;
  logic [2:0] settle_sel = 3'd7;
  logic irq_mask = 0;
  logic [N_SRC-1:0] src_en = '0, src_pend = '0;
  logic [1:0] mode_o;
  logic [N_PERIPH-1:0] periph_ce;
  logic cpu_ce, exc_start;

  always #5 clk = ~clk;

  wmode_ctrl uut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .stby_sel(stby_sel),
    .lspd_sel(lspd_sel), .mspd_sel(mspd_sel), .tclk_sel(tclk_sel),
    .settle_sel(settle_sel), .irq_mask(irq_mask), .src_en(src_en),
    .src_pend(src_pend), .mode_o(mode_o), .periph_ce(periph_ce),
    .cpu_ce(cpu_ce), .exc_start(exc_start)
  );

  typedef struct {
    string               req;
    logic [1:0]          mode;
    logic [N_PERIPH-1:0] ce;
    logic                cpu;
    logic                exc;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Driver side: expectation for the outputs after the coming rising edge
  task automatic expect_next(string req, logic [1:0] m, logic [N_PERIPH-1:0] ce,
                             logic cpu, logic exc);
    exp_t e;
    e.req = req; e.mode = m; e.ce = ce; e.cpu = cpu; e.exc = exc;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (mode_o !== e.mode || periph_ce !== e.ce || cpu_ce !== e.cpu || exc_start !== e.exc) begin
        n_fail++;
        $display("FAIL %s: got mode=%0d ce=%h cpu=%b exc=%b, expected mode=%0d ce=%h cpu=%b exc=%b",
                 e.req, mode_o, periph_ce, cpu_ce, exc_start, e.mode, e.ce, e.cpu, e.exc);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick();
    // R1 reset state
    tick();
    expect_next("R1", 2'd0, ALL, 1'b1, 1'b0);
    tick();
    rst = 0;

    // R11 sleep with standby but no timer clock: no effect
    sleep_i = 1; stby_sel = 1; tclk_sel = 0;
    expect_next("R11", 2'd0, ALL, 1'b1, 1'b0);
    tick();
    sleep_i = 0;

    // R10 doze: cpu gated, mode and enables unchanged
    stby_sel = 0; sleep_i = 1;
    expect_next("R10", 2'd0, ALL, 1'b0, 1'b0);
    tick();
    sleep_i = 0;
    src_pend[0] = 1;  // R4 pending but disabled
    expect_next("R4", 2'd0, ALL, 1'b0, 1'b0);
    tick();
    src_en[0] = 1; irq_mask = 1;  // R4 masked
    expect_next("R4", 2'd0, ALL, 1'b0, 1'b0);
    tick();
    irq_mask = 0;
    expect_next("R10", 2'd0, ALL, 1'b1, 1'b1);
    tick();
    expect_next("R8", 2'd0, ALL, 1'b1, 1'b0);
    tick();
    src_pend = '0; src_en = '0;

    // R2 watch entry, subactive target
    stby_sel = 1; tclk_sel = 1; lspd_sel = 1; sleep_i = 1;
    expect_next("R2", 2'd3, KEEP, 1'b0, 1'b0);
    tick();
    sleep_i = 0;
    src_pend[7] = 1;  // wake pin 3, disabled
    expect_next("R4", 2'd3, KEEP, 1'b0, 1'b0);
    tick();
    src_en[7] = 1; irq_mask = 1;
    expect_next("R4", 2'd3, KEEP, 1'b0, 1'b0);
    tick();
    irq_mask = 0;
    expect_next("R5", 2'd2, ALL, 1'b1, 1'b1);
    tick();
    src_pend = '0;
    expect_next("R8", 2'd2, ALL, 1'b1, 1'b0);
    tick();

    // R2 from subactive; wake to medium speed with 16-edge settle
    sleep_i = 1;
    expect_next("R3", 2'd3, KEEP, 1'b0, 1'b0);
    tick();
    sleep_i = 0; lspd_sel = 0; mspd_sel = 1; settle_sel = 3'd7;
    src_en = '0; src_en[3] = 1; src_pend[3] = 1;
    for (int i = 0; i < 16; i++) begin
      if (i == 1) src_pend = '0;
      sleep_i = (i >= 1 && i <= 10);  // R9 sleep during settling
      expect_next("R7", 2'd3, KEEP, 1'b0, 1'b0);
      tick();
    end
    sleep_i = 0;
    expect_next("R6", 2'd1, ALL, 1'b1, 1'b1);
    tick();
    expect_next("R9", 2'd1, ALL, 1'b1, 1'b0);
    tick();

    // Full-speed target with longest settle and several sources at once
    sleep_i = 1;
    expect_next("R2", 2'd3, KEEP, 1'b0, 1'b0);
    tick();
    sleep_i = 0; mspd_sel = 0; settle_sel = 3'd0;
    src_en = '1; src_pend[0] = 1; src_pend[1] = 1; src_pend[2] = 1;
    for (int i = 0; i < 2048; i++) begin
      expect_next("R7", 2'd3, KEEP, 1'b0, 1'b0);
      tick();
    end
    expect_next("R6", 2'd0, ALL, 1'b1, 1'b1);
    tick();
    for (int i = 0; i < 4; i++) begin
      expect_next("R8", 2'd0, ALL, 1'b1, 1'b0);
      tick();
    end
    src_pend = '0;
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule